// File: doc/BRIEF.md
# Interrupt Pin Delivery and End-of-Interrupt Engine

This block sits between a set of interrupt input lines and the interrupt message fabric. Each line has a routing entry, held elsewhere, that gives a vector, a destination, a destination mode, a delivery mode, a trigger mode (edge or level) and a mask. The engine keeps one pending bit and one remote-IRR bit per line. From line events and those entries it decides when a line must be turned into a message. It issues at most one message at a time over a valid/ready port, and when several lines want service it takes the lowest-numbered line first.

End-of-interrupt broadcasts come in by vector. Every line whose vector matches is reported as acknowledged. For a level EOI, the engine clears remote-IRR and sends the interrupt again if the line is still pending and unmasked. A line that keeps asserting forms an interrupt storm. To stop it from starving the processors, each line counts back-to-back redeliveries. When a line reaches the storm limit, its redelivery waits for a shared timer. When the timer expires, every level line that is pending with remote-IRR clear is serviced.

A strobe on a line reports its new level. Level 1 is an assertion and level 0 is a deassertion. When a routing entry is rewritten, the owner of that entry raises the rewrite pulse for the line.

Top module: `irq_route_engine`

## Requirements
- R1: After reset, no message is offered, every remote-IRR bit reads 0 and no acknowledge pulse is active.
- R2: A strobe with level 0 clears the pending bit of that line. A later rewrite of a level entry on that line then produces no message.
- R3: An assertion on an edge line whose pending bit is already set is coalesced and produces no message.
- R4: An assertion on a level line whose remote-IRR bit is set produces no message, although the line still becomes pending.
- R5: A masked line never produces a message. Its request is dropped and its pending bit is kept.
- R6: Delivering an edge message clears the pending bit of its line, so the next assertion is delivered again.
- R7: Delivering a level message sets remote-IRR when msg_reach is 1 at the handshake, and leaves it clear when msg_reach is 0.
- R8: An EOI pulses eoi_ack for every line whose vector equals the EOI vector, one cycle after the EOI. Only a level EOI (eoi_trig_level=1) clears remote-IRR on the matching lines.
- R9: On a level EOI, a matching line that is unmasked and still pending is delivered again. A matching line that is not pending is not delivered.
- R10: Each line counts consecutive level-EOI redeliveries. The STORM_LIMIT-th such EOI does not deliver. It resets the count and starts the deferral timer instead. A masked or non-pending line at a level EOI resets its count.
- R11: When the deferral timer expires, about DEFER_CYCLES cycles after it was started, every level line that is pending with remote-IRR clear is delivered.
- R12: A rewrite pulse clears remote-IRR on its line. If the entry is level-triggered and the line is pending, delivery is tried again.
- R13: Requests are served lowest line number first. An offered message holds msg_valid and all of its fields stable until msg_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_strobe | input | NUM_LINES | Per-line event strobe |
| line_level | input | NUM_LINES | Level reported with the strobe (1 = asserted) |
| ent_vector | input | NUM_LINES*VEC_W | Vector of each entry, line i at bits [i*VEC_W +: VEC_W] |
| ent_dest | input | NUM_LINES*DEST_W | Destination of each entry |
| ent_dest_mode | input | NUM_LINES | Destination mode of each entry |
| ent_deliv | input | NUM_LINES*3 | Delivery mode of each entry |
| ent_trig_level | input | NUM_LINES | 1 = level-triggered, 0 = edge-triggered |
| ent_mask | input | NUM_LINES | 1 = entry masked |
| ent_write | input | NUM_LINES | Pulse: entry of that line was rewritten |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_trig_level | input | 1 | 1 = level EOI, 0 = edge EOI |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_reach | input | 1 | At handshake: message reached at least one destination |
| msg_line | output | LINE_W | Line the message belongs to |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_deliv | output | 3 | Message delivery mode |
| msg_trig_level | output | 1 | Message trigger mode |
| remote_irr | output | NUM_LINES | Remote-IRR bit of each line |
| eoi_ack | output | NUM_LINES | One-cycle acknowledge notification per line |

## Verification
The hardest state to reach is the storm deferral. It needs a level line that stays pending through STORM_LIMIT consecutive level EOIs, each of which lands while the line is unmasked. The bench therefore builds the block with a small storm limit and a short deferral. It holds one line asserted and issues EOIs back to back, counting the immediate redeliveries before the one that is withheld. A second level line is parked pending with remote-IRR clear by masking it at its assertion and unmasking it without a rewrite. The timer expiry must then deliver both lines in line order, and the next EOI must start a fresh count.

// File: rtl/irq_route_pkg.sv
// Package irq_route_pkg
// Shared constants and types for the interrupt delivery engine.
// Assumes the delivery mode field is three bits wide.
package irq_route_pkg;
    localparam int DELIV_W = 3;
    typedef logic [DELIV_W-1:0] deliv_t;
endpackage

// File: rtl/irq_pin_slot.sv
// Module irq_pin_slot
// Per-line state: pending bit, remote-IRR bit, service request and
// storm counter. Decides when the line asks for a message and when a
// level EOI must be deferred to the shared timer.
// Assumes grant, done_edge and done_level_hit are single-cycle pulses
// from the message picker, and at most one done pulse per cycle.
module irq_pin_slot #(
    parameter int VEC_W       = 8,
    parameter int STORM_LIMIT = 10000,
    localparam int CNT_W      = $clog2(STORM_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic             line_level,
    input  logic             trig_level,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_trig_level,
    input  logic             ent_write,
    input  logic             timer_fire,
    input  logic             grant,
    input  logic             done_edge,
    input  logic             done_level_hit,
    output logic             req,
    output logic             remote_irr,
    output logic             ack,
    output logic             defer_req
);
    logic             pend_q, rirr_q, req_q, ack_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_n, rirr_n, req_n;
    logic [CNT_W-1:0] cnt_n;
    logic             eoi_hit;

    assign eoi_hit = eoi_valid && (vector == eoi_vector);

    // Next-state of the line, events applied in a fixed order.
    always_comb begin
        pend_n    = pend_q;
        rirr_n    = rirr_q;
        req_n     = req_q;
        cnt_n     = cnt_q;
        defer_req = 1'b0;
        if (grant) req_n = 1'b0;
        if (done_edge) pend_n = 1'b0;
        if (done_level_hit) rirr_n = 1'b1;
        if (line_strobe) begin
            if (!line_level) begin
                pend_n = 1'b0;
            end else if (!trig_level) begin
                if (!pend_n) req_n = 1'b1;
                pend_n = 1'b1;
            end else begin
                if (!rirr_n) req_n = 1'b1;
                pend_n = 1'b1;
            end
        end
        if (eoi_hit && eoi_trig_level) begin
            rirr_n = 1'b0;
            if (!masked && pend_n) begin
                if (cnt_q == CNT_W'(STORM_LIMIT - 1)) begin
                    cnt_n     = '0;
                    defer_req = 1'b1;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                    req_n = 1'b1;
                end
            end else begin
                cnt_n = '0;
            end
        end
        if (ent_write) begin
            rirr_n = 1'b0;
            if (trig_level && pend_n) req_n = 1'b1;
        end
        if (timer_fire && trig_level && pend_n && !rirr_n) req_n = 1'b1;
    end

    // State registers of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rirr_q <= 1'b0;
            req_q  <= 1'b0;
            cnt_q  <= '0;
            ack_q  <= 1'b0;
        end else begin
            pend_q <= pend_n;
            rirr_q <= rirr_n;
            req_q  <= req_n;
            cnt_q  <= cnt_n;
            ack_q  <= eoi_hit;
        end
    end

    assign req        = req_q;
    assign remote_irr = rirr_q;
    assign ack        = ack_q;

    // R2: a deassert strobe leaves the line not pending
    assert_drop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !line_level) |=> !pend_q);
    // R6: edge delivery clears pending unless a new assertion arrives
    assert_edge_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_edge && !(line_strobe && line_level)) |=> !pend_q);
    // R10: the storm counter never reaches the limit
    assert_cnt_below_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(STORM_LIMIT));
    // R10: a deferral restarts the count
    assert_defer_resets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        defer_req |=> (cnt_q == '0));
    // R4: assertion on a level line with remote-IRR set does not raise a request
    assert_level_coalesce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && line_level && trig_level && rirr_q && !req_q && !eoi_hit
         && !ent_write && !timer_fire) |=> !req_q);
endmodule

// File: rtl/irq_msg_picker.sv
// Module irq_msg_picker
// Picks the lowest requesting line while no message is outstanding,
// drops the pick if the line is masked, and otherwise holds the
// captured entry on the message port until it is accepted.
// Assumes entry fields are stable in the cycle a line is picked.
module irq_msg_picker
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int VEC_W     = 8,
    parameter int DEST_W    = 8,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINES-1:0]          req,
    input  logic [NUM_LINES*VEC_W-1:0]    ent_vector,
    input  logic [NUM_LINES*DEST_W-1:0]   ent_dest,
    input  logic [NUM_LINES-1:0]          ent_dest_mode,
    input  logic [NUM_LINES*DELIV_W-1:0]  ent_deliv,
    input  logic [NUM_LINES-1:0]          ent_trig_level,
    input  logic [NUM_LINES-1:0]          ent_mask,
    input  logic                          msg_ready,
    input  logic                          msg_reach,
    output logic [NUM_LINES-1:0]          grant,
    output logic [NUM_LINES-1:0]          done_edge,
    output logic [NUM_LINES-1:0]          done_level_hit,
    output logic                          msg_valid,
    output logic [LINE_W-1:0]             msg_line,
    output logic [VEC_W-1:0]              msg_vector,
    output logic [DEST_W-1:0]             msg_dest,
    output logic                          msg_dest_mode,
    output deliv_t                        msg_deliv,
    output logic                          msg_trig_level
);
    logic              found;
    logic [LINE_W-1:0] sel;
    logic              pick;
    logic              accept;

    // Lowest-numbered requesting line.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (!found && req[i]) begin
                found = 1'b1;
                sel   = LINE_W'(i);
            end
        end
    end

    assign pick   = found && !msg_valid;
    assign accept = msg_valid && msg_ready;

    // Per-line grant and completion pulses.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            grant[i]          = pick && (sel == LINE_W'(i));
            done_edge[i]      = accept && (msg_line == LINE_W'(i)) && !msg_trig_level;
            done_level_hit[i] = accept && (msg_line == LINE_W'(i)) && msg_trig_level && msg_reach;
        end
    end

    // Message register: load on an unmasked pick, release on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid      <= 1'b0;
            msg_line       <= '0;
            msg_vector     <= '0;
            msg_dest       <= '0;
            msg_dest_mode  <= 1'b0;
            msg_deliv      <= '0;
            msg_trig_level <= 1'b0;
        end else if (accept) begin
            msg_valid <= 1'b0;
        end else if (pick && !ent_mask[sel]) begin
            msg_valid      <= 1'b1;
            msg_line       <= sel;
            msg_vector     <= ent_vector[sel*VEC_W +: VEC_W];
            msg_dest       <= ent_dest[sel*DEST_W +: DEST_W];
            msg_dest_mode  <= ent_dest_mode[sel];
            msg_deliv      <= ent_deliv[sel*DELIV_W +: DELIV_W];
            msg_trig_level <= ent_trig_level[sel];
        end
    end

    // R5: a masked pick never turns into a message
    assert_masked_no_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pick && ent_mask[sel]) |=> !msg_valid);
    // R13: an offered message is held until accepted
    assert_hold_until_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_line)
            && $stable(msg_vector) && $stable(msg_dest) && $stable(msg_deliv)));
    // R13: at most one line granted per cycle
    assert_one_grant_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/irq_defer_timer.sv
// Module irq_defer_timer
// One shared deferral timer. A start while idle arms it; starts while
// it runs are ignored. It fires for one cycle DEFER_CYCLES after arming.
// Assumes DEFER_CYCLES is at least 1.
module irq_defer_timer #(
    parameter int DEFER_CYCLES = 2500000,
    localparam int TW          = $clog2(DEFER_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fire
);
    logic          run_q;
    logic [TW-1:0] cnt_q;

    assign fire = run_q && (cnt_q == '0);

    // Arm, count down, and disarm on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q) begin
            if (start) begin
                run_q <= 1'b1;
                cnt_q <= TW'(DEFER_CYCLES - 1);
            end
        end else if (fire) begin
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    // R11: the timer fires for a single cycle
    assert_fire_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/irq_route_engine.sv
// Module irq_route_engine
// Top of the interrupt delivery and EOI engine: one state slot per
// line, a lowest-first message picker and a shared deferral timer.
// Assumes routing entries are owned outside and ent_write pulses
// whenever an entry changes.
module irq_route_engine
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES    = 24,
    parameter int VEC_W        = 8,
    parameter int DEST_W       = 8,
    parameter int STORM_LIMIT  = 10000,
    parameter int DEFER_CYCLES = 2500000,
    localparam int LINE_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES-1:0]         line_strobe,
    input  logic [NUM_LINES-1:0]         line_level,
    input  logic [NUM_LINES*VEC_W-1:0]   ent_vector,
    input  logic [NUM_LINES*DEST_W-1:0]  ent_dest,
    input  logic [NUM_LINES-1:0]         ent_dest_mode,
    input  logic [NUM_LINES*DELIV_W-1:0] ent_deliv,
    input  logic [NUM_LINES-1:0]         ent_trig_level,
    input  logic [NUM_LINES-1:0]         ent_mask,
    input  logic [NUM_LINES-1:0]         ent_write,
    input  logic                         eoi_valid,
    input  logic [VEC_W-1:0]             eoi_vector,
    input  logic                         eoi_trig_level,
    output logic                         msg_valid,
    input  logic                         msg_ready,
    input  logic                         msg_reach,
    output logic [LINE_W-1:0]            msg_line,
    output logic [VEC_W-1:0]             msg_vector,
    output logic [DEST_W-1:0]            msg_dest,
    output logic                         msg_dest_mode,
    output logic [DELIV_W-1:0]           msg_deliv,
    output logic                         msg_trig_level,
    output logic [NUM_LINES-1:0]         remote_irr,
    output logic [NUM_LINES-1:0]         eoi_ack
);
    logic [NUM_LINES-1:0] req, grant, done_edge, done_level_hit, defer_req;
    logic                 timer_fire;

    // One state slot per line.
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_slot
            irq_pin_slot #(
                .VEC_W      (VEC_W),
                .STORM_LIMIT(STORM_LIMIT)
            ) u_slot (
                .clk           (clk),
                .rst_n         (rst_n),
                .line_strobe   (line_strobe[g]),
                .line_level    (line_level[g]),
                .trig_level    (ent_trig_level[g]),
                .masked        (ent_mask[g]),
                .vector        (ent_vector[g*VEC_W +: VEC_W]),
                .eoi_valid     (eoi_valid),
                .eoi_vector    (eoi_vector),
                .eoi_trig_level(eoi_trig_level),
                .ent_write     (ent_write[g]),
                .timer_fire    (timer_fire),
                .grant         (grant[g]),
                .done_edge     (done_edge[g]),
                .done_level_hit(done_level_hit[g]),
                .req           (req[g]),
                .remote_irr    (remote_irr[g]),
                .ack           (eoi_ack[g]),
                .defer_req     (defer_req[g])
            );
        end
    endgenerate

    irq_msg_picker #(
        .NUM_LINES(NUM_LINES),
        .VEC_W    (VEC_W),
        .DEST_W   (DEST_W)
    ) u_pick (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .ent_vector    (ent_vector),
        .ent_dest      (ent_dest),
        .ent_dest_mode (ent_dest_mode),
        .ent_deliv     (ent_deliv),
        .ent_trig_level(ent_trig_level),
        .ent_mask      (ent_mask),
        .msg_ready     (msg_ready),
        .msg_reach     (msg_reach),
        .grant         (grant),
        .done_edge     (done_edge),
        .done_level_hit(done_level_hit),
        .msg_valid     (msg_valid),
        .msg_line      (msg_line),
        .msg_vector    (msg_vector),
        .msg_dest      (msg_dest),
        .msg_dest_mode (msg_dest_mode),
        .msg_deliv     (msg_deliv),
        .msg_trig_level(msg_trig_level)
    );

    irq_defer_timer #(
        .DEFER_CYCLES(DEFER_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(|defer_req),
        .fire (timer_fire)
    );

    // R1: nothing offered or acknowledged in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!msg_valid && remote_irr == '0 && eoi_ack == '0));
endmodule

// File: tb/irq_route_engine_test.sv
// Scoreboard bench: tasks push expected messages, a monitor pops and
// compares them at each accepted handshake.
module irq_route_engine_test;
    localparam int N     = 4;
    localparam int VW    = 8;
    localparam int DW    = 8;
    localparam int LIM   = 3;
    localparam int DEFER = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    line_strobe = '0, line_level = '0, ent_write = '0;
    logic [N*VW-1:0] ent_vector;
    logic [N*DW-1:0] ent_dest;
    logic [N-1:0]    ent_dest_mode, ent_trig_level, ent_mask;
    logic [N*3-1:0]  ent_deliv;
    logic            eoi_valid = 1'b0, eoi_trig_level = 1'b0;
    logic [VW-1:0]   eoi_vector = '0;
    logic            msg_valid, msg_ready = 1'b1, msg_reach = 1'b1;
    logic [1:0]      msg_line;
    logic [VW-1:0]   msg_vector;
    logic [DW-1:0]   msg_dest;
    logic            msg_dest_mode, msg_trig_level;
    logic [2:0]      msg_deliv;
    logic [N-1:0]    remote_irr, eoi_ack;

    int ev[N];
    int trig[N];
    int msk[N];

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_vector[i*VW +: VW] = VW'(ev[i]);
            ent_dest[i*DW +: DW]   = DW'(8'h10 + i);
            ent_dest_mode[i]       = i[0];
            ent_deliv[i*3 +: 3]    = 3'(i + 1);
            ent_trig_level[i]      = trig[i][0];
            ent_mask[i]            = msk[i][0];
        end
    end

    irq_route_engine #(
        .NUM_LINES(N), .VEC_W(VW), .DEST_W(DW),
        .STORM_LIMIT(LIM), .DEFER_CYCLES(DEFER)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_level(line_level),
        .ent_vector(ent_vector), .ent_dest(ent_dest), .ent_dest_mode(ent_dest_mode),
        .ent_deliv(ent_deliv), .ent_trig_level(ent_trig_level), .ent_mask(ent_mask),
        .ent_write(ent_write), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .eoi_trig_level(eoi_trig_level), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_reach(msg_reach), .msg_line(msg_line), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode), .msg_deliv(msg_deliv),
        .msg_trig_level(msg_trig_level), .remote_irr(remote_irr), .eoi_ack(eoi_ack)
    );

    typedef struct {
        int    line;
        int    vec;
        int    trg;
        string tag;
    } exp_t;
    exp_t q[$];
    int nchk = 0;
    int nfail = 0;

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare every accepted message with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (q.size() == 0) begin
                chk("R13 unexpected message on line", int'(msg_line), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " line"}, int'(msg_line), e.line);
                chk({e.tag, " vector"}, int'(msg_vector), e.vec);
                chk({e.tag, " dest"}, int'(msg_dest), 8'h10 + e.line);
                chk({e.tag, " dest mode"}, int'(msg_dest_mode), e.line % 2);
                chk({e.tag, " deliv"}, int'(msg_deliv), e.line + 1);
                chk({e.tag, " trig"}, int'(msg_trig_level), e.trg);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_msg(int l, string tag);
        exp_t e;
        e.line = l; e.vec = ev[l]; e.trg = trig[l]; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic strobe(logic [N-1:0] which, logic lvl);
        step();
        line_strobe = which;
        line_level  = lvl ? which : '0;
        step();
        line_strobe = '0;
        line_level  = '0;
    endtask

    task automatic rewrite(int l);
        step();
        ent_write[l] = 1'b1;
        step();
        ent_write = '0;
    endtask

    task automatic eoi(int v, logic lvl, output logic [N-1:0] ack);
        step();
        eoi_valid = 1'b1;
        eoi_vector = VW'(v);
        eoi_trig_level = lvl;
        @(posedge clk);
        #1;
        eoi_valid = 1'b0;
        @(negedge clk);
        ack = eoi_ack;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic qempty(string tag);
        chk({tag, " outstanding expected messages"}, q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [N-1:0] ack;
        for (int i = 0; i < N; i++) begin
            ev[i] = 8'h20 + i; trig[i] = 0; msk[i] = 0;
        end
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 msg_valid after reset", int'(msg_valid), 0);
        chk("R1 remote_irr after reset", int'(remote_irr), 0);
        chk("R1 eoi_ack after reset", int'(eoi_ack), 0);

        // Edge line 0: delivery clears pending so a repeat is delivered
        expect_msg(0, "R6 first edge");
        strobe(4'b0001, 1); idle(8);
        expect_msg(0, "R6 repeat after delivery");
        strobe(4'b0001, 1); idle(8);
        qempty("R6");

        // Masked edge line 1: no message, pending kept, repeat coalesced
        msk[1] = 1;
        strobe(4'b0010, 1); idle(8);
        qempty("R5 masked");
        msk[1] = 0;
        strobe(4'b0010, 1); idle(8);
        qempty("R3 coalesced edge");
        strobe(4'b0010, 0); idle(2);
        expect_msg(1, "R2 assert after drop");
        strobe(4'b0010, 1); idle(8);
        qempty("R2");

        // Level line 2
        trig[2] = 1;
        expect_msg(2, "R7 level delivery");
        strobe(4'b0100, 1); idle(8);
        chk("R7 remote_irr set", int'(remote_irr[2]), 1);
        strobe(4'b0100, 1); idle(8);
        qempty("R4 level coalesced");
        expect_msg(2, "R9 redelivery on EOI");
        eoi(ev[2], 1, ack);
        chk("R8 ack of line 2", int'(ack), 4'b0100);
        idle(8);
        qempty("R9");
        strobe(4'b0100, 0);
        eoi(ev[2], 1, ack); idle(8);
        qempty("R9 no redelivery when not pending");
        chk("R8 level EOI clears remote_irr", int'(remote_irr[2]), 0);
        rewrite(2); idle(8);
        qempty("R2 dropped level line not pending");

        // msg_reach = 0 leaves remote-IRR clear
        msg_reach = 1'b0;
        expect_msg(2, "R7 unreached delivery");
        strobe(4'b0100, 1); idle(8);
        chk("R7 remote_irr stays clear", int'(remote_irr[2]), 0);
        msg_reach = 1'b1;
        strobe(4'b0100, 0);
        eoi(ev[2], 1, ack);

        // Edge EOI leaves remote-IRR alone
        expect_msg(2, "R8 setup");
        strobe(4'b0100, 1); idle(8);
        eoi(ev[2], 0, ack); idle(4);
        chk("R8 edge EOI ack", int'(ack), 4'b0100);
        chk("R8 edge EOI keeps remote_irr", int'(remote_irr[2]), 1);
        strobe(4'b0100, 0);
        eoi(ev[2], 1, ack); idle(4);

        // Storm on line 2, line 3 parked pending with remote-IRR clear
        expect_msg(2, "R10 storm start");
        strobe(4'b0100, 1); idle(8);
        trig[3] = 1; msk[3] = 1;
        strobe(4'b1000, 1); idle(8);
        msk[3] = 0;
        expect_msg(2, "R10 immediate 1");
        eoi(ev[2], 1, ack); idle(8);
        expect_msg(2, "R10 immediate 2");
        eoi(ev[2], 1, ack); idle(8);
        eoi(ev[2], 1, ack); idle(10);
        qempty("R10 limit reached defers");
        chk("R10 remote_irr clear while deferred", int'(remote_irr[2]), 0);
        expect_msg(2, "R11 timer delivers line 2");
        expect_msg(3, "R11 timer delivers line 3");
        idle(DEFER + 20);
        qempty("R11");
        chk("R11 remote_irr after timer", int'(remote_irr), 4'b1100);
        expect_msg(2, "R10 count restarted");
        eoi(ev[2], 1, ack); idle(8);
        qempty("R10 restart");
        strobe(4'b1100, 0);
        eoi(ev[2], 1, ack);
        eoi(ev[3], 1, ack); idle(4);

        // Rewrite of a level entry
        trig[1] = 1; msk[1] = 1;
        strobe(4'b0010, 0);
        strobe(4'b0010, 1); idle(8);
        qempty("R5 masked level");
        msk[1] = 0;
        expect_msg(1, "R12 rewrite reattempts");
        rewrite(1); idle(8);
        chk("R12 remote_irr after delivery", int'(remote_irr[1]), 1);
        expect_msg(1, "R12 rewrite clears remote_irr and redelivers");
        rewrite(1); idle(8);
        trig[1] = 0;
        rewrite(1); idle(8);
        qempty("R12 edge entry rewrite");
        chk("R12 rewrite clears remote_irr", int'(remote_irr[1]), 0);
        strobe(4'b0010, 0);

        // EOI matching two lines
        ev[3] = ev[1];
        eoi(ev[1], 0, ack);
        chk("R8 shared vector acks", int'(ack), 4'b1010);
        ev[3] = 8'h23;

        // Priority and hold under back-pressure
        trig[0] = 0; trig[3] = 0;
        strobe(4'b1001, 0);
        msg_ready = 1'b0;
        expect_msg(0, "R13 lowest first");
        expect_msg(3, "R13 then higher");
        strobe(4'b1001, 1); idle(5);
        @(negedge clk);
        chk("R13 held valid", int'(msg_valid), 1);
        chk("R13 held line", int'(msg_line), 0);
        idle(5);
        @(negedge clk);
        chk("R13 still held line", int'(msg_line), 0);
        msg_ready = 1'b1;
        idle(10);
        qempty("R13");

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule